// File: doc/BRIEF.md
# Packet-Filter VM Integer ALU

A purely combinational execution unit for a register machine with 64-bit registers. Each cycle it receives an already split instruction: a 4-bit operation code, a width bit (32-bit or 64-bit class), a bit that picks the second operand, an 8-bit offset qualifier, a 32-bit immediate, and the current values of the destination and source registers. It returns the value to be written back to the destination register. It also returns two flags. One marks an encoding the unit cannot execute. The other marks a multiply, divide or modulo, which belong to a separate unit.

The covered operations are add, subtract, bitwise or/and/xor, the three shifts, negate, plain move, sign-extending move and byte-order conversion. A 32-bit class result is always zero-extended into the 64-bit register. Byte-order conversion can swap bytes, or only truncate when the target order equals the host order. The parameter `HOST_BIG_ENDIAN` sets the host order, so the same netlist serves either host.

Top module: `vmalu_top`

## Requirements
- R1: Codes ADD=0x0, SUB=0x1, OR=0x4, AND=0x5 and XOR=0xa compute dst+b, dst-b, dst|b, dst&b and dst^b, wrapping silently. In the 64-bit class (wideMode=1) the 32-bit immediate is sign-extended to 64 bits before use.
- R2: srcSel=0 takes the immediate as the second operand b, and srcSel=1 takes srcVal. MOV (code 0xb, offset 0) returns b with either source.
- R3: In the 32-bit class (wideMode=0) every operation except byte swap (code 0xd) works on the low 32 bits, and result[63:32] is zero.
- R4: LSH=0x6, RSH=0x7 and ARSH=0xc shift dst by b masked to 6 bits (64-bit class) or 5 bits (32-bit class). ARSH fills with the sign bit of the operating width.
- R5: NEG=0x8 returns the two's complement of dst when srcSel=0. With srcSel=1 it is illegal.
- R6: MOV with offsetQual 8, 16 or 32 sign-extends the low 8, 16 or 32 bits of srcVal. The 32-bit class accepts only 8 and 16. This move requires srcSel=1, and any other nonzero offset is illegal.
- R7: END=0xd takes its width (16, 32 or 64) from the immediate. Any other immediate is illegal. Bits above the width are zero in the result.
- R8: For END in the 32-bit class, srcSel=0 targets little-endian and srcSel=1 targets big-endian. The bytes are reversed only when the target differs from the host order; otherwise the value is only truncated. In the 64-bit class the bytes are always reversed, and srcSel=1 is illegal.
- R9: Codes 0x2, 0x3 and 0x9 raise unsupportedOp, keep illegalOp low and return zero.
- R10: Codes 0xe and 0xf, and every illegal combination listed above, raise illegalOp with a zero result. illegalOp and unsupportedOp are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 4 | Operation code |
| wideMode | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| srcSel | input | 1 | Operand select / target byte order |
| offsetQual | input | 8 | Offset qualifier (sign-extend width) |
| immVal | input | 32 | Immediate operand / swap width |
| dstVal | input | 64 | Destination register value |
| srcVal | input | 64 | Source register value |
| result | output | 64 | Value written back to the destination |
| illegalOp | output | 1 | Illegal encoding, result forced to zero |
| unsupportedOp | output | 1 | Multiply/divide/modulo code, result zero |

## Verification
The hardest cases to reach are the byte-order conversions where the target order equals the host order. They only truncate, and they exist only for one setting of the host parameter. The bench therefore drives every input pattern into two instances at once, one built for a little-endian host and one for a big-endian host. It checks both against an arithmetic model. The sweep covers every code, both widths, both source bits, legal and illegal offsets, and immediates that hit each swap width as well as ones that miss.

// File: rtl/vmalu_pkg.sv
package vmalu_pkg;

  localparam logic [3:0] CODE_ADD  = 4'h0;
  localparam logic [3:0] CODE_SUB  = 4'h1;
  localparam logic [3:0] CODE_MUL  = 4'h2;
  localparam logic [3:0] CODE_DIV  = 4'h3;
  localparam logic [3:0] CODE_OR   = 4'h4;
  localparam logic [3:0] CODE_AND  = 4'h5;
  localparam logic [3:0] CODE_LSH  = 4'h6;
  localparam logic [3:0] CODE_RSH  = 4'h7;
  localparam logic [3:0] CODE_NEG  = 4'h8;
  localparam logic [3:0] CODE_MOD  = 4'h9;
  localparam logic [3:0] CODE_XOR  = 4'ha;
  localparam logic [3:0] CODE_MOV  = 4'hb;
  localparam logic [3:0] CODE_ARSH = 4'hc;
  localparam logic [3:0] CODE_END  = 4'hd;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_ADD, SEL_SUB, SEL_OR, SEL_AND, SEL_XOR,
    SEL_LSH, SEL_RSH, SEL_ARSH, SEL_NEG, SEL_MOV, SEL_MOVSX, SEL_SWAP
  } opSel_t;

  // extSel / swapSel: 0 -> 8/16 bits, 1 -> 16/32 bits, 2 -> 32/64 bits
  typedef struct packed {
    logic       is64;
    logic       useReg;
    opSel_t     sel;
    logic [1:0] extSel;
    logic [1:0] swapSel;
    logic       swapOn;
    logic       illegal;
    logic       unsupported;
  } aluCtrl_t;

endpackage

// File: rtl/vmalu_ctrl.sv
module vmalu_ctrl
  import vmalu_pkg::*;
#(
  parameter bit HOST_BIG_ENDIAN = 1'b0,
  parameter int IMMW = 32
) (
  input  logic [3:0]      opCode,
  input  logic            wideMode,
  input  logic            srcSel,
  input  logic [7:0]      offsetQual,
  input  logic [IMMW-1:0] immVal,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl             = '0;
    ctrl.is64        = wideMode;
    ctrl.useReg      = srcSel;
    ctrl.sel         = SEL_ZERO;
    unique case (opCode)
      CODE_ADD:  ctrl.sel = SEL_ADD;
      CODE_SUB:  ctrl.sel = SEL_SUB;
      CODE_OR:   ctrl.sel = SEL_OR;
      CODE_AND:  ctrl.sel = SEL_AND;
      CODE_XOR:  ctrl.sel = SEL_XOR;
      CODE_LSH:  ctrl.sel = SEL_LSH;
      CODE_RSH:  ctrl.sel = SEL_RSH;
      CODE_ARSH: ctrl.sel = SEL_ARSH;
      CODE_MUL, CODE_DIV, CODE_MOD: ctrl.unsupported = 1'b1;
      CODE_NEG: begin
        if (srcSel) ctrl.illegal = 1'b1;
        else        ctrl.sel = SEL_NEG;
      end
      CODE_MOV: begin
        if (offsetQual == 8'd0) ctrl.sel = SEL_MOV;
        else if (!srcSel) ctrl.illegal = 1'b1;
        else begin
          ctrl.sel = SEL_MOVSX;
          case (offsetQual)
            8'd8:    ctrl.extSel = 2'd0;
            8'd16:   ctrl.extSel = 2'd1;
            8'd32:   if (wideMode) ctrl.extSel = 2'd2; else ctrl.illegal = 1'b1;
            default: ctrl.illegal = 1'b1;
          endcase
        end
      end
      CODE_END: begin
        ctrl.sel    = SEL_SWAP;
        ctrl.swapOn = wideMode | (srcSel != HOST_BIG_ENDIAN);
        if (wideMode && srcSel) ctrl.illegal = 1'b1;
        case (immVal)
          IMMW'(16): ctrl.swapSel = 2'd0;
          IMMW'(32): ctrl.swapSel = 2'd1;
          IMMW'(64): ctrl.swapSel = 2'd2;
          default:   ctrl.illegal = 1'b1;
        endcase
      end
      default: ctrl.illegal = 1'b1;
    endcase
    if (ctrl.illegal || ctrl.unsupported) ctrl.sel = SEL_ZERO;
  end

endmodule

// File: rtl/vmalu_swap.sv
module vmalu_swap #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  input  logic [1:0]      swapSel,
  input  logic            swapOn,
  output logic [XLEN-1:0] swapRes
);

  localparam int NWID = 3;  // 16, 32, 64 bit variants
  logic [XLEN-1:0] cand [NWID];

  for (genvar g = 0; g < NWID; g++) begin : g_width
    localparam int NB = 2 << g;
    logic [XLEN-1:0] rev;
    logic [XLEN-1:0] trunc;
    for (genvar k = 0; k < XLEN / 8; k++) begin : g_byte
      if (k < NB) begin : g_in
        assign rev[8*k +: 8]   = value[8*(NB-1-k) +: 8];
        assign trunc[8*k +: 8] = value[8*k +: 8];
      end else begin : g_out
        assign rev[8*k +: 8]   = 8'h00;
        assign trunc[8*k +: 8] = 8'h00;
      end
    end
    assign cand[g] = swapOn ? rev : trunc;
  end

  always_comb begin
    swapRes = '0;
    if (swapSel < 2'(NWID)) swapRes = cand[swapSel];
  end

endmodule

// File: rtl/vmalu_dp.sv
module vmalu_dp
  import vmalu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  aluCtrl_t        ctrl,
  input  logic [IMMW-1:0] immVal,
  input  logic [XLEN-1:0] dstVal,
  input  logic [XLEN-1:0] srcVal,
  output logic [XLEN-1:0] result
);

  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [XLEN-1:0] opB;
  logic [SHW-1:0]  shAmt;
  logic [HALF-1:0] loDst;
  logic [XLEN-1:0] swapRes;
  logic [XLEN-1:0] raw;

  assign opB   = ctrl.useReg ? srcVal : {{(XLEN-IMMW){immVal[IMMW-1]}}, immVal};
  assign shAmt = ctrl.is64 ? opB[SHW-1:0] : {1'b0, opB[SHW-2:0]};
  assign loDst = dstVal[HALF-1:0];

  vmalu_swap #(.XLEN(XLEN)) u_swap (
    .value   (dstVal),
    .swapSel (ctrl.swapSel),
    .swapOn  (ctrl.swapOn),
    .swapRes (swapRes)
  );

  always_comb begin
    raw = '0;
    unique case (ctrl.sel)
      SEL_ADD:  raw = dstVal + opB;
      SEL_SUB:  raw = dstVal - opB;
      SEL_OR:   raw = dstVal | opB;
      SEL_AND:  raw = dstVal & opB;
      SEL_XOR:  raw = dstVal ^ opB;
      SEL_NEG:  raw = -dstVal;
      SEL_MOV:  raw = opB;
      SEL_LSH:  raw = dstVal << shAmt;
      SEL_RSH:  raw = ctrl.is64 ? (dstVal >> shAmt) : {{HALF{1'b0}}, loDst >> shAmt};
      SEL_ARSH: raw = ctrl.is64 ? XLEN'($signed(dstVal) >>> shAmt)
                                : {{HALF{1'b0}}, HALF'($signed(loDst) >>> shAmt)};
      SEL_MOVSX: begin
        case (ctrl.extSel)
          2'd0:    raw = {{(XLEN-8){srcVal[7]}}, srcVal[7:0]};
          2'd1:    raw = {{(XLEN-16){srcVal[15]}}, srcVal[15:0]};
          default: raw = {{(XLEN-32){srcVal[31]}}, srcVal[31:0]};
        endcase
      end
      SEL_SWAP: raw = swapRes;
      default:  raw = '0;
    endcase
    if (!ctrl.is64 && ctrl.sel != SEL_SWAP) result = {{HALF{1'b0}}, raw[HALF-1:0]};
    else                                    result = raw;
  end

endmodule

// File: rtl/vmalu_top.sv
module vmalu_top
  import vmalu_pkg::*;
#(
  parameter bit HOST_BIG_ENDIAN = 1'b0
) (
  input  logic [3:0]  opCode,
  input  logic        wideMode,
  input  logic        srcSel,
  input  logic [7:0]  offsetQual,
  input  logic [31:0] immVal,
  input  logic [63:0] dstVal,
  input  logic [63:0] srcVal,
  output logic [63:0] result,
  output logic        illegalOp,
  output logic        unsupportedOp
);

  aluCtrl_t ctrl;

  vmalu_ctrl #(.HOST_BIG_ENDIAN(HOST_BIG_ENDIAN), .IMMW(32)) u_ctrl (
    .opCode     (opCode),
    .wideMode   (wideMode),
    .srcSel     (srcSel),
    .offsetQual (offsetQual),
    .immVal     (immVal),
    .ctrl       (ctrl)
  );

  vmalu_dp #(.XLEN(64), .IMMW(32)) u_dp (
    .ctrl   (ctrl),
    .immVal (immVal),
    .dstVal (dstVal),
    .srcVal (srcVal),
    .result (result)
  );

  assign illegalOp     = ctrl.illegal;
  assign unsupportedOp = ctrl.unsupported;

endmodule

// File: rtl/vmalu_chk.sv
module vmalu_chk (
  input logic [3:0]  opCode,
  input logic        wideMode,
  input logic        srcSel,
  input logic [7:0]  offsetQual,
  input logic [31:0] immVal,
  input logic [63:0] dstVal,
  input logic [63:0] srcVal,
  input logic [63:0] result,
  input logic        illegalOp,
  input logic        unsupportedOp
);

  logic okFlags;
  assign okFlags = !illegalOp && !unsupportedOp;

  always_comb begin
    a_r3_upper_zero: assert (wideMode || opCode == 4'hd || result[63:32] == 32'h0);
    a_r9_unsupported_code: assert (unsupportedOp == (opCode == 4'h2 || opCode == 4'h3 || opCode == 4'h9));
    a_r10_flags_exclusive: assert (!(illegalOp && unsupportedOp));
    a_r10_flag_zero_result: assert (okFlags || result == 64'h0);
    a_r5_neg_needs_imm: assert (!(opCode == 4'h8 && srcSel) || illegalOp);
    a_r7_swap16_upper: assert (!(opCode == 4'hd && okFlags && immVal == 32'd16) || result[63:16] == 48'h0);
    a_r8_wide_swap16: assert (!(opCode == 4'hd && okFlags && wideMode && immVal == 32'd16)
                              || result[15:0] == {dstVal[7:0], dstVal[15:8]});
    a_r6_sx8_sign: assert (!(opCode == 4'hb && okFlags && offsetQual == 8'd8)
                           || result[31:7] == {25{srcVal[7]}});
  end

endmodule

bind vmalu_top vmalu_chk u_chk (
  .opCode        (opCode),
  .wideMode      (wideMode),
  .srcSel        (srcSel),
  .offsetQual    (offsetQual),
  .immVal        (immVal),
  .dstVal        (dstVal),
  .srcVal        (srcVal),
  .result        (result),
  .illegalOp     (illegalOp),
  .unsupportedOp (unsupportedOp)
);

// File: tb/vmalu_top_tb.sv
`timescale 1ns/1ps
module vmalu_top_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [3:0]  opCode = '0;
  logic        wideMode = 1'b0;
  logic        srcSel = 1'b0;
  logic [7:0]  offsetQual = '0;
  logic [31:0] immVal = '0;
  logic [63:0] dstVal = '0;
  logic [63:0] srcVal = '0;
  logic [63:0] resLe, resBe;
  logic        illLe, illBe, unsLe, unsBe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  vmalu_top #(.HOST_BIG_ENDIAN(1'b0)) u_dut (
    .opCode(opCode), .wideMode(wideMode), .srcSel(srcSel), .offsetQual(offsetQual),
    .immVal(immVal), .dstVal(dstVal), .srcVal(srcVal),
    .result(resLe), .illegalOp(illLe), .unsupportedOp(unsLe));

  vmalu_top #(.HOST_BIG_ENDIAN(1'b1)) u_dutBe (
    .opCode(opCode), .wideMode(wideMode), .srcSel(srcSel), .offsetQual(offsetQual),
    .immVal(immVal), .dstVal(dstVal), .srcVal(srcVal),
    .result(resBe), .illegalOp(illBe), .unsupportedOp(unsBe));

  function automatic logic [63:0] byteRev(input logic [63:0] v, input int nb, input bit rev);
    logic [63:0] r = '0;
    for (int k = 0; k < nb; k++)
      r[8*k +: 8] = rev ? v[8*(nb-1-k) +: 8] : v[8*k +: 8];
    return r;
  endfunction

  task automatic model(input bit hostBe, output logic [63:0] r, output logic ill, output logic uns);
    logic [63:0] b;
    logic [31:0] t32;
    int sh;
    int nb;
    r = '0; ill = 0; uns = 0;
    b = srcSel ? srcVal : {{32{immVal[31]}}, immVal};
    sh = wideMode ? int'(b[5:0]) : int'(b[4:0]);
    case (opCode)
      4'h0: r = dstVal + b;
      4'h1: r = dstVal - b;
      4'h4: r = dstVal | b;
      4'h5: r = dstVal & b;
      4'ha: r = dstVal ^ b;
      4'h6: r = dstVal << sh;
      4'h7: begin
        if (wideMode) r = dstVal >> sh;
        else begin t32 = dstVal[31:0] >> sh; r = {32'h0, t32}; end
      end
      4'hc: begin
        if (wideMode) r = 64'($signed(dstVal) >>> sh);
        else begin t32 = 32'($signed(dstVal[31:0]) >>> sh); r = {32'h0, t32}; end
      end
      4'h8: if (srcSel) ill = 1; else r = 64'h0 - dstVal;
      4'hb: begin
        if (offsetQual == 0) r = b;
        else if (!srcSel) ill = 1;
        else if (offsetQual == 8) r = {{56{srcVal[7]}}, srcVal[7:0]};
        else if (offsetQual == 16) r = {{48{srcVal[15]}}, srcVal[15:0]};
        else if (offsetQual == 32 && wideMode) r = {{32{srcVal[31]}}, srcVal[31:0]};
        else ill = 1;
      end
      4'hd: begin
        nb = (immVal == 16) ? 2 : (immVal == 32) ? 4 : (immVal == 64) ? 8 : 0;
        if (nb == 0 || (wideMode && srcSel)) ill = 1;
        else r = byteRev(dstVal, nb, wideMode || (srcSel != hostBe));
      end
      4'h2, 4'h3, 4'h9: uns = 1;
      default: ill = 1;
    endcase
    if (!wideMode && opCode != 4'hd) r[63:32] = 32'h0;
    if (ill || uns) r = '0;
  endtask

  function automatic string reqOf(input logic [3:0] c);
    case (c)
      4'h2, 4'h3, 4'h9: return "R9";
      4'he, 4'hf:       return "R10";
      4'h6, 4'h7, 4'hc: return "R4";
      4'h8:             return "R5";
      4'hb:             return (offsetQual == 0) ? "R2" : "R6";
      4'hd:             return wideMode ? "R7" : "R8";
      default:          return wideMode ? "R1" : "R3";
    endcase
  endfunction

  task automatic checkOne(input string tag, input bit hostBe, input logic [63:0] gotR,
                          input logic gotI, input logic gotU);
    logic [63:0] eR;
    logic eI, eU;
    model(hostBe, eR, eI, eU);
    total++;
    if (gotR !== eR || gotI !== eI || gotU !== eU) begin
      bad++;
      $display("FAIL %s host=%0d code=%h w=%0d s=%0d off=%0d imm=%h dst=%h src=%h: got %h/%0d/%0d exp %h/%0d/%0d",
               tag, hostBe, opCode, wideMode, srcSel, offsetQual, immVal, dstVal, srcVal,
               gotR, gotI, gotU, eR, eI, eU);
    end
  endtask

  task automatic apply(input logic [3:0] c, input bit w, input bit s, input logic [7:0] o,
                       input logic [31:0] im, input logic [63:0] d, input logic [63:0] sr);
    @(negedge clk);
    opCode = c; wideMode = w; srcSel = s; offsetQual = o; immVal = im; dstVal = d; srcVal = sr;
    #1;
  endtask

  task automatic directed(input string tag, input logic [63:0] expR, input logic expI,
                          input logic expU);
    total++;
    if (resLe !== expR || illLe !== expI || unsLe !== expU) begin
      bad++;
      $display("FAIL %s directed: got %h/%0d/%0d exp %h/%0d/%0d", tag, resLe, illLe, unsLe,
               expR, expI, expU);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] imms [6];
    logic [63:0] ops [8];
    logic [7:0]  offs [5];
    imms = '{32'd16, 32'd32, 32'd64, 32'h8000_0001, 32'd7, 32'hFFFF_FFC1};
    ops  = '{64'h1122_3344_5566_7788, 64'h8000_0000_0000_0080,
             64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_7F41,
             64'h0000_0000_0000_0041, 64'h7FFF_FFFF_FFFF_FFFF,
             64'h0000_0000_0000_0023, 64'hF0E1_D2C3_B4A5_9687};
    offs = '{8'd0, 8'd8, 8'd16, 8'd32, 8'd3};
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // all-zero inputs: ADD of zeros
    apply(4'h0, 0, 0, 0, 0, 0, 0);
    directed("R1 idle", 64'h0, 0, 0);

    apply(4'h0, 1, 0, 0, 32'hFFFF_FFFF, 64'd5, 0);
    directed("R1 add sext imm", 64'd4, 0, 0);
    apply(4'h0, 0, 0, 0, 32'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    directed("R3 wrap 32", 64'h0, 0, 0);
    apply(4'hb, 1, 0, 0, 32'h8000_0000, 0, 64'h1234);
    directed("R2 mov imm", 64'hFFFF_FFFF_8000_0000, 0, 0);
    apply(4'hb, 1, 1, 0, 32'h8000_0000, 0, 64'h1234);
    directed("R2 mov reg", 64'h1234, 0, 0);
    apply(4'h6, 1, 1, 0, 0, 64'd1, 64'd65);
    directed("R4 lsh mask", 64'd2, 0, 0);
    apply(4'hc, 0, 0, 0, 32'd31, 64'h0000_0000_8000_0000, 0);
    directed("R4 arsh 32", 64'h0000_0000_FFFF_FFFF, 0, 0);
    apply(4'h8, 1, 1, 0, 0, 64'd1, 0);
    directed("R5 neg reg", 64'h0, 1, 0);
    apply(4'h8, 1, 0, 0, 0, 64'd1, 0);
    directed("R5 neg", 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    apply(4'hb, 0, 1, 8'd8, 0, 0, 64'h80);
    directed("R6 sx8 32", 64'h0000_0000_FFFF_FF80, 0, 0);
    apply(4'hb, 0, 1, 8'd32, 0, 0, 64'h8000_0000);
    directed("R6 sx32 in 32", 64'h0, 1, 0);
    apply(4'hd, 1, 0, 0, 32'd48, 64'h1122, 0);
    directed("R7 bad width", 64'h0, 1, 0);
    apply(4'hd, 0, 1, 0, 32'd16, 64'h1122_3344_5566_7788, 0);
    directed("R8 to big 16", 64'h8877, 0, 0);
    apply(4'hd, 0, 0, 0, 32'd16, 64'h1122_3344_5566_7788, 0);
    directed("R8 to little 16", 64'h7788, 0, 0);
    apply(4'hd, 1, 1, 0, 32'd32, 64'h1122_3344_5566_7788, 0);
    directed("R8 wide src1", 64'h0, 1, 0);
    apply(4'h3, 1, 0, 0, 32'd2, 64'd9, 0);
    directed("R9 divide", 64'h0, 0, 1);
    apply(4'he, 1, 0, 0, 32'd2, 64'd9, 0);
    directed("R10 code e", 64'h0, 1, 0);

    for (int c = 0; c < 16; c++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 2; s++)
          for (int o = 0; o < 5; o++)
            for (int i = 0; i < 6; i++)
              for (int p = 0; p < 8; p++) begin
                apply(4'(c), w[0], s[0], offs[o], imms[i], ops[p], ops[(p + 3) % 8]);
                checkOne(reqOf(4'(c)), 1'b0, resLe, illLe, unsLe);
                checkOne(reqOf(4'(c)), 1'b1, resBe, illBe, unsBe);
              end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule